// File: doc/BRIEF.md
# Notch Calibration Sweep Controller

This controller trims a switched-capacitor notch filter onto its target frequency. The filter's extra grounded capacitors are binary weighted, so raising the tuning code adds capacitance and moves the notch lower. A start pulse launches a linear search from code zero. After each code change the controller waits a programmable settle interval and then reads two comparator flags: one says the output amplitude is below the notch threshold, the other says the filter output is present at all.

The search ends in one of three ways. It locks and holds the current code when both flags are set. It reports a power fault and returns the code to zero when the output is absent, or when the flag pair is not a valid combination. It reports a no-lock error, leaving the code at all ones, when the top code is passed without a match. One code drives two identical switch banks. The result stays on the outputs until the next start.

Top module: `notch_sweep_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the code is zero and busy, done, locked, power fault and no-lock are all low.
- R2: Both bank outputs equal the tuning code at all times, and line n of each bank carries code bit n, the bit whose capacitor weighs 2^n least-significant units.
- R3: A start pulse seen while idle makes busy high, the code zero and clears locked, power fault and no-lock at the next clock edge.
- R4: In a sweep the code rises by exactly one per step. Each step takes settle_cycles_i + 1 clocks, so a lock at code T with fresh status is reported (settle_cycles_i + 1) * (T + 1) clocks after the start edge.
- R5: Synchronised status {amp_low_i, out_live_i} = 2'b11 ends the sweep with locked high and the current code held.
- R6: Synchronised status 2'b00 (no output) or 2'b10 (invalid) ends the sweep with the power fault flag high and the code returned to zero.
- R7: Status 2'b01 at code all ones ends the sweep with the no-lock flag high and the code left at all ones. At any other code, 2'b01 advances the sweep.
- R8: A start pulse while busy is ignored: the code and the step sequence continue unchanged.
- R9: Done is a pulse of exactly one cycle at the end of every sweep. The code and the outcome flags then stay unchanged until the next start.
- R10: Both status inputs pass through two flip-flop stages, so a decision at a clock edge uses the input values sampled two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a sweep |
| amp_low_i | input | 1 | Comparator flag: amplitude below the notch threshold |
| out_live_i | input | 1 | Comparator flag: filter output present |
| settle_cycles_i | input | SETTLE_W | Extra wait clocks after each code change |
| code_o | output | CODE_W | Current tuning code |
| bank_a_o | output | CODE_W | Switch lines of the first capacitor bank |
| bank_b_o | output | CODE_W | Switch lines of the second capacitor bank |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| locked_o | output | 1 | Last sweep found the notch |
| pwr_fault_o | output | 1 | Last sweep aborted on absent or invalid status |
| no_lock_o | output | 1 | Last sweep passed the top code without a match |

## Verification
The bench builds the block with the default 8-bit code and a 6-bit settle field. That lets it run complete 256-code sweeps to the no-lock end within a few hundred clocks per sweep. Settle values of 2 and 3 keep the sampled status fresh, so the lock code and the cycle count can be predicted exactly. A run with zero settle shows the two-stage synchroniser lag: the sweep overshoots the target by two codes. A behavioural model of the filter feeds the status flags from the driven code, with power-off and invalid-flag injection in the middle of a sweep.

// File: rtl/notch_sweep_ctrl.sv
module notch_sweep_ctrl #(
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                amp_low_i,
  input  logic                out_live_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic [CODE_W-1:0]   code_o,
  output logic [CODE_W-1:0]   bank_a_o,
  output logic [CODE_W-1:0]   bank_b_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                locked_o,
  output logic                pwr_fault_o,
  output logic                no_lock_o
);

  localparam logic [CODE_W-1:0] CODE_TOP = '1;

  logic [1:0]          meta_q, stat_q;
  logic [CODE_W-1:0]   code_q;
  logic [SETTLE_W-1:0] wait_q;
  logic                busy_q, done_q, lock_q, fault_q, nolock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 2'b00;
      stat_q   <= 2'b00;
      code_q   <= '0;
      wait_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      lock_q   <= 1'b0;
      fault_q  <= 1'b0;
      nolock_q <= 1'b0;
    end else begin
      meta_q <= {amp_low_i, out_live_i};
      stat_q <= meta_q;
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q   <= 1'b1;
          code_q   <= '0;
          wait_q   <= settle_cycles_i;
          lock_q   <= 1'b0;
          fault_q  <= 1'b0;
          nolock_q <= 1'b0;
        end
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else begin
        case (stat_q)
          2'b11: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            lock_q <= 1'b1;
          end
          2'b01: begin
            if (code_q == CODE_TOP) begin
              busy_q   <= 1'b0;
              done_q   <= 1'b1;
              nolock_q <= 1'b1;
            end else begin
              code_q <= code_q + 1'b1;
              wait_q <= settle_cycles_i;
            end
          end
          default: begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            code_q  <= '0;
          end
        endcase
      end
    end
  end

  assign code_o      = code_q;
  assign bank_a_o    = code_q;
  assign bank_b_o    = code_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign locked_o    = lock_q;
  assign pwr_fault_o = fault_q;
  assign no_lock_o   = nolock_q;

  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && code_o != $past(code_o)) |-> (code_o == $past(code_o) + 1'b1));

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !start_i) |=> (locked_o && $stable(code_o)));

  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fault_o |-> (code_o == '0 && !busy_o));

  p_nolock_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    no_lock_o |-> (code_o == CODE_TOP && !busy_o));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({locked_o, pwr_fault_o, no_lock_o}));

endmodule

// File: tb/notch_sweep_ctrl_test.sv
module notch_sweep_ctrl_test;
  localparam int CW = 8;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic amp = 1'b0;
  logic live = 1'b0;
  logic [SW-1:0] settle = '0;
  logic [CW-1:0] code, bank_a, bank_b;
  logic busy, done, locked, fault, nolock;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int  target = 1000;
  bit  powered = 1'b1;
  bit  bad10 = 1'b0;

  int  m_code, m_wait;
  bit  m_busy, m_done, m_lock, m_fault, m_nolock;
  bit [1:0] m_s1, m_s2;

  notch_sweep_ctrl #(.CODE_W(CW), .SETTLE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .amp_low_i(amp), .out_live_i(live),
    .settle_cycles_i(settle), .code_o(code), .bank_a_o(bank_a), .bank_b_o(bank_b),
    .busy_o(busy), .done_o(done), .locked_o(locked), .pwr_fault_o(fault), .no_lock_o(nolock)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 0; m_wait = 0; m_busy = 0; m_done = 0;
      m_lock = 0; m_fault = 0; m_nolock = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_code = 0; m_wait = int'(settle);
          m_lock = 0; m_fault = 0; m_nolock = 0;
        end
      end else if (m_wait > 0) begin
        m_wait--;
      end else if (m_s2 == 2'b11) begin
        m_busy = 0; m_done = 1; m_lock = 1;
      end else if (m_s2 == 2'b01) begin
        if (m_code == (1 << CW) - 1) begin
          m_busy = 0; m_done = 1; m_nolock = 1;
        end else begin
          m_code++; m_wait = int'(settle);
        end
      end else begin
        m_busy = 0; m_done = 1; m_fault = 1; m_code = 0;
      end
      m_s2 = m_s1;
      m_s1 = {amp, live};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(code) == m_code, "R4", "code", int'(code), m_code);
      chk(bank_a == code && bank_b == code, "R2", "banks", int'(bank_b), int'(code));
      chk(busy == m_busy, "R8", "busy", int'(busy), int'(m_busy));
      chk(done == m_done, "R9", "done", int'(done), int'(m_done));
      chk(locked == m_lock, "R5", "locked", int'(locked), int'(m_lock));
      chk(fault == m_fault, "R6", "power fault", int'(fault), int'(m_fault));
      chk(nolock == m_nolock, "R7", "no-lock", int'(nolock), int'(m_nolock));
    end
    amp  <= bad10 ? 1'b1 : (powered && int'(code) == target);
    live <= bad10 ? 1'b0 : powered;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && code == '0 && !locked && !fault && !nolock, "R3", "start state",
        int'({busy, locked, fault, nolock}), 8);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 100000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_code(input int v);
    for (int i = 0; i < 100000 && int'(code) != v; i++) @(negedge clk);
  endtask

  initial begin
    int n;
    idle(3);
    chk(code == '0 && !busy && !done && !locked && !fault && !nolock, "R1", "in reset",
        int'(code) + int'(busy), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    chk(code == '0 && !busy && !locked && !fault && !nolock, "R1", "after reset",
        int'(code) + int'(busy), 0);

    // lock at 70 with settle 3
    target = 70; settle = 3; idle(4);
    kick(); wait_done(n);
    chk(n == 4 * 71, "R4", "cycles to lock", n, 4 * 71);
    chk(locked && int'(code) == 70, "R5", "locked code", int'(code), 70);
    idle(1);
    chk(!done, "R9", "done width", int'(done), 0);
    idle(10);
    chk(locked && int'(code) == 70, "R9", "result held", int'(code), 70);

    // full sweep without a match
    target = 1000; settle = 2; idle(4);
    kick(); wait_done(n);
    chk(nolock && code == '1, "R7", "no-lock at top", int'(code), 255);

    // zero settle: two-stage lag overshoots by two codes
    target = 2; settle = 0; idle(6);
    kick(); wait_done(n);
    chk(locked && int'(code) == 4, "R10", "lagged lock code", int'(code), 4);

    // power lost mid sweep
    target = 1000; settle = 2; idle(4);
    kick(); wait_code(20);
    powered = 1'b0;
    wait_done(n);
    chk(fault && code == '0, "R6", "power-off abort", int'(code), 0);
    powered = 1'b1;

    // invalid status 10 mid sweep
    idle(4);
    kick(); wait_code(10);
    bad10 = 1'b1;
    wait_done(n);
    chk(fault && code == '0 && !locked, "R6", "invalid-status abort", int'(fault), 1);
    bad10 = 1'b0;

    // start while busy is ignored
    target = 40; idle(4);
    kick(); wait_code(15);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && int'(code) >= 15, "R8", "start while busy", int'(code), 15);
    wait_done(n);
    chk(locked && int'(code) == 40, "R5", "lock after ignored start", int'(code), 40);

    // immediate lock at code zero
    target = 0; settle = 3; idle(6);
    kick(); wait_done(n);
    chk(n == 4 && locked && code == '0, "R4", "lock at zero", n, 4);

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule